// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Controller

This block watches a vector of general-purpose input pins for level changes and folds them into four group interrupt requests. The pins fall into four groups of unequal size: pins 0 to 7, pins 8 to 14, pins 16 to 23 and pins 24 to 26. Pin 15 belongs to no group. Each pin takes part only when its own mask bit is set. A change in either direction on a participating pin of an enabled group latches that group's pending flag. The group's request output is high while the flag is pending, the group is enabled and the global interrupt enable is high.

Software programs the block through a small register bus. One control register holds the group enables. A pending register shows the four flags and is cleared by writing ones. There is one mask register per group. An interrupt source that serves a group can also clear its flag with a one-cycle acknowledge pulse. Pin inputs are asynchronous: each one passes through a two-flop synchronizer before the block compares it with its previous sample.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: A change on an enabled pin drives only the request of its own group: pins 0-7 drive irq_o[0], pins 8-14 drive irq_o[1], pins 16-23 drive irq_o[2] and pins 24-26 drive irq_o[3]. Pin 15 never drives a request.
- R2: Each group has a mask register, at address 2 for group 0, 3 for group 1, 4 for group 2 and 5 for group 3. Bit b of a group's mask register belongs to the pin whose number is the group's lowest pin plus b. A pin whose mask bit is zero causes no request.
- R3: A rising change and a falling change on an enabled pin each set the group's pending flag.
- R4: irq_o[g] is high exactly one cycle after the pending flag of group g, its enable bit and gie_i are all high together. A flag that is pending while gie_i is low stays pending, and its request rises one cycle after gie_i goes high.
- R5: The control register is at address 0. Bit g is the enable of group g. Bits 7:4 always read as zero. A read returns data on rdata_o one cycle after the address is presented.
- R6: The pending register is at address 1, with bit g for group g. Writing a one to bit g clears that flag. Writing a zero leaves it unchanged.
- R7: A one-cycle pulse on ack_i[g] clears the pending flag of group g. A change detected in the same cycle as the acknowledge or the clearing write keeps the flag set.
- R8: Mask bits with no pin behind them read as zero and cannot be set: bit 7 of the group 1 mask and bits 7:3 of the group 3 mask.
- R9: A change in a group whose enable bit is zero does not set the group's pending flag.
- R10: With every enable set, a pin change applied between clock edges shows on irq_o at the fourth rising edge that follows. The path is two synchronizer flops, the pending flag and the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pins_i | input | 27 | Asynchronous pin levels, bit n is pin n |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-group acknowledge pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for both reads and writes |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data for the previous cycle's address |
| irq_o | output | 4 | Registered per-group interrupt requests |

## Verification
The hardest case to reach from the ports is a new pin change that is detected in the same cycle an acknowledge clears a flag that is already pending. The detection point lies two synchronizer cycles inside the block, so the stimulus counts edges. It first sets the flag with one pin. It then toggles a second pin and raises ack_i exactly two edges later, so that the pulse falls on the detection cycle. It checks that the request stays high through that cycle and the ones after it. A lone acknowledge then clears the request. The monitor also confirms that a masked pin, pin 15 and a disabled group leave every request low, and that the pending register still shows a flag set while gie_i is low.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int N_GRP     = 4;
  localparam int GRP_SLOT  = 8;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PEND = 1;
  localparam int ADDR_MASK = 2;

  function automatic int grp_lo(input int g);
    case (g)
      0:       return 0;
      1:       return 8;
      2:       return 16;
      default: return 24;
    endcase
  endfunction

  function automatic int grp_w(input int g);
    case (g)
      0:       return 8;
      1:       return 7;
      2:       return 8;
      default: return 3;
    endcase
  endfunction

  function automatic logic [31:0] used_pins();
    logic [31:0] m;
    m = '0;
    for (int g = 0; g < N_GRP; g++)
      for (int b = 0; b < grp_w(g); b++)
        m[grp_lo(g) + b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/pinchg_group.sv
module pinchg_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  input  logic         gie_i,
  input  logic         ack_i,
  input  logic         w1c_i,
  output logic         pend_o,
  output logic         irq_o
);
  logic hit;
  logic pend_q;
  logic irq_q;

  assign hit = en_i && (|((cur_i ^ prev_i) & mask_i));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (hit)                pend_q <= 1'b1;
      else if (ack_i | w1c_i) pend_q <= 1'b0;
      irq_q <= pend_q && en_i && gie_i;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R2 and R9: a flag rises only after a masked-in change in an enabled group
  a_r2_set_needs_masked_change: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pend_q) |-> $past(en_i && (|((cur_i ^ prev_i) & mask_i))));
  // R7: a clear without a competing change empties the flag
  a_r7_clear_wins_alone: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(ack_i || w1c_i) && !$past(hit)) |-> !pend_q);
  // R4: a request needs the global enable one cycle earlier
  a_r4_irq_needs_gie: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> $past(gie_i && pend_q));
endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl
  import pinchg_pkg::*;
#(
  parameter int N_PINS = 27,
  parameter int DW     = 8,
  parameter int AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [N_PINS-1:0] pins_i,
  input  logic              gie_i,
  input  logic [N_GRP-1:0]  ack_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_GRP-1:0]  irq_o
);
  localparam logic [31:0] USED = used_pins();

  logic [N_PINS-1:0]   cur, prev;
  logic [N_GRP-1:0]    ctrl_q;
  logic [GRP_SLOT-1:0] mask_q [N_GRP];
  logic [N_GRP-1:0]    pend, w1c;
  logic [DW-1:0]       rd_mux, rdata_q;
  logic [N_PINS-1:0]   unused_pins;

  pinchg_sync #(.W(N_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pins_i),
    .cur_o (cur),
    .prev_o(prev)
  );

  assign unused_pins = (cur ^ prev) & ~USED[N_PINS-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) ctrl_q <= '0;
    else if (wr_en_i && addr_i == AW'(ADDR_CTRL)) ctrl_q <= wdata_i[N_GRP-1:0];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int W  = grp_w(g);
    localparam logic [GRP_SLOT-1:0] WMASK = GRP_SLOT'((1 << W) - 1);

    always_ff @(posedge clk_i) begin
      if (rst_i) mask_q[g] <= '0;
      else if (wr_en_i && addr_i == AW'(ADDR_MASK + g)) mask_q[g] <= wdata_i[GRP_SLOT-1:0] & WMASK;
    end

    assign w1c[g] = wr_en_i && addr_i == AW'(ADDR_PEND) && wdata_i[g];

    pinchg_group #(.W(W)) u_grp (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .cur_i (cur[LO +: W]),
      .prev_i(prev[LO +: W]),
      .mask_i(mask_q[g][W-1:0]),
      .en_i  (ctrl_q[g]),
      .gie_i (gie_i),
      .ack_i (ack_i[g]),
      .w1c_i (w1c[g]),
      .pend_o(pend[g]),
      .irq_o (irq_o[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(ADDR_CTRL))      rd_mux[N_GRP-1:0] = ctrl_q;
    else if (addr_i == AW'(ADDR_PEND)) rd_mux[N_GRP-1:0] = pend;
    else
      for (int g = 0; g < N_GRP; g++)
        if (addr_i == AW'(ADDR_MASK + g)) rd_mux[GRP_SLOT-1:0] = mask_q[g];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  // R5: the reserved control bits never read back as one
  a_r5_ctrl_reserved: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(addr_i == AW'(ADDR_CTRL)) |-> rdata_o[DW-1:N_GRP] == '0);
  // R8: the missing pin slot of group 1 never reads back as one
  a_r8_g1_hole: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(addr_i == AW'(ADDR_MASK + 1)) |-> !rdata_o[GRP_SLOT-1]);
  // R4: a request is raised only for an enabled group
  a_r4_irq_enabled: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o & ~$past(ctrl_q)) == '0);
endmodule

// File: tb/test_pinchg_irq_ctrl.sv
module test_pinchg_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          due;
    bit          is_rd;
    logic [7:0]  exp;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [26:0] pins = '0;
  logic        gie = 0;
  logic [3:0]  ack = '0;
  logic        wr_en = 0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  irq;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  item_t sbq[$];

  pinchg_irq_ctrl i_pinchg_irq_ctrl (
    .clk_i(clk), .rst_i(rst), .pins_i(pins), .gie_i(gie), .ack_i(ack),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops every expectation whose cycle has come
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        logic [7:0] act;
        act = sbq[i].is_rd ? rdata : {4'b0, irq};
        checks++;
        if (act !== sbq[i].exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h (cycle %0d)", sbq[i].tag, act, sbq[i].exp, cyc);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_irq(input int off, input logic [3:0] e, input string tag);
    item_t it;
    it.due = cyc + off; it.is_rd = 0; it.exp = {4'b0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    tick(1);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    it.due = cyc + 1; it.is_rd = 1; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    tick(1);
  endtask

  task automatic pulse_ack(input int g);
    ack[g] = 1'b1;
    tick(1);
    ack = '0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    exp_irq(1, 4'h0, "R4 reset requests low");
    rd(0, 8'h00, "R5 reset control");
    rd(1, 8'h00, "R6 reset pending");

    wr(0, 8'hFF);
    rd(0, 8'h0F, "R5 reserved bits read zero");
    wr(2, 8'h0F);
    wr(3, 8'hFF);
    rd(3, 8'h7F, "R8 group1 hole bit");
    wr(4, 8'hFF);
    wr(5, 8'hFF);
    rd(5, 8'h07, "R8 group3 upper bits");
    gie = 1;
    tick(2);

    // R10 latency, R1 group 0, R3 rising
    pins[2] = 1;
    exp_irq(3, 4'h0, "R10 not before fourth edge");
    exp_irq(4, 4'h1, "R3 rising change group0");
    tick(5);
    rd(1, 8'h01, "R6 pending readback");
    exp_irq(2, 4'h0, "R7 ack clears");
    pulse_ack(0);
    tick(3);

    // R3 falling, R6 write-one clear
    pins[2] = 0;
    exp_irq(4, 4'h1, "R3 falling change");
    tick(5);
    exp_irq(2, 4'h0, "R6 write one clears");
    wr(1, 8'h01);
    tick(3);
    pins[3] = 1;
    tick(5);
    exp_irq(3, 4'h1, "R6 write zero no effect");
    wr(1, 8'h00);
    tick(3);
    pulse_ack(0);
    tick(3);

    // R2 masked pin
    pins[5] = 1;
    exp_irq(4, 4'h0, "R2 masked pin ignored");
    exp_irq(6, 4'h0, "R2 masked pin ignored late");
    tick(7);

    // R1 other groups
    pins[8] = 1;
    exp_irq(4, 4'h2, "R1 pin8 to group1");
    tick(5); pulse_ack(1); tick(3);
    pins[20] = 1;
    exp_irq(4, 4'h4, "R1 pin20 to group2");
    tick(5); pulse_ack(2); tick(3);
    pins[26] = 1;
    exp_irq(4, 4'h8, "R1 pin26 to group3");
    tick(5); pulse_ack(3); tick(3);
    pins[15] = 1;
    exp_irq(4, 4'h0, "R1 pin15 ignored");
    exp_irq(6, 4'h0, "R8 pin15 ignored late");
    tick(7);

    // R9 disabled group
    wr(0, 8'h0E);
    pins[1] = 1;
    exp_irq(4, 4'h0, "R9 disabled group no request");
    tick(5);
    rd(1, 8'h00, "R9 disabled group no pending");
    wr(0, 8'h0F);
    exp_irq(2, 4'h0, "R9 enable later stays quiet");
    tick(3);

    // R4 global enable gating
    gie = 0;
    pins[1] = 0;
    exp_irq(4, 4'h0, "R4 gie low holds request");
    tick(5);
    rd(1, 8'h01, "R4 pending while gie low");
    gie = 1;
    exp_irq(1, 4'h1, "R4 request after gie high");
    tick(2);
    pulse_ack(0);
    tick(3);

    // R7 change coincides with acknowledge
    pins[0] = 1;
    tick(5);
    pins[1] = 1;
    tick(2);
    exp_irq(1, 4'h1, "R7 collision keeps request");
    exp_irq(2, 4'h1, "R7 collision keeps request next");
    exp_irq(3, 4'h1, "R7 collision keeps request late");
    pulse_ack(0);
    tick(3);
    rd(1, 8'h01, "R7 collision keeps pending");
    exp_irq(2, 4'h0, "R7 lone ack clears");
    pulse_ack(0);
    tick(4);

    done = 1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule